// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Timer Channel

This block is a single channel of a multi-channel timer. A shared 32-bit counter is supplied from outside, together with a strobe that marks each cycle in which that counter has just moved to a new value. On each such strobe the channel compares the counter with its own comparator. When the two are exactly equal, the channel raises a one-cycle fire pulse, which the interrupt logic downstream turns into an interrupt.

In one-shot mode the comparator stays where software put it. A value that is already behind the counter only fires after the counter wraps around. In periodic mode a second register holds the period, and every match moves the comparator forward by that period. A comparator write in periodic mode always reloads the period. It reloads the live comparator only when a self-clearing arm bit in the configuration word is set. When the global run input rises, or when a periodic comparator write lands while running, a sequential remainder unit realigns the comparator to the first point of its period grid that lies strictly ahead of the counter.

Software sees a 64-bit configuration word and the comparator through one write port with byte-lane enables. Capability bits in the configuration word are read-only and survive every write.

Top module: `match_timer_chan`

## Requirements
- R1: After reset the comparator is 0xFFFFFFFF and fire is 0. The configuration word is 0x00F00000_00005000: the upper half holds the route-capability mask, bit 12 (periodic-capable) and bit 14 (direct-delivery-capable) are 1, and all other bits are 0.
- R2: A configuration write (wr_sel=0) stores only the writable fields: bit 0 periodic mode, bit 1 arm, bits 7:3 route, bit 8 direct delivery. Bits 12, 13 (wide-counter, always 0), 14 and 63:32 keep their reset value. Bit 2 (narrow-force) and every other bit read 0.
- R3: Lane i of wr_lanes enables data bits 8i+7:8i. A write leaves the bytes of disabled lanes unchanged.
- R4: In one-shot mode a comparator write (wr_sel=1) merges wr_data[31:0] into the comparator under wr_lanes[3:0]. A match leaves the comparator unchanged. A value behind the counter fires only when the counter wraps to it.
- R5: In periodic mode a comparator write always merges into the period. It copies the merged period into the comparator only if the arm bit is 1. Any comparator write, in either mode, clears the arm bit.
- R6: fire is 1 for exactly the cycle after a cycle in which ctr_run=1, ctr_step=1 and ctr_val equals the comparator. It is 0 otherwise, in particular while ctr_run=0 or ctr_step=0.
- R7: In periodic mode a match sets the comparator to comparator + period (mod 2^32) on the same edge that raises fire.
- R8: While the periodic-mode bit is 0 the period is held at zero, so after the mode is set again a match leaves the comparator unchanged.
- R9: A rise of ctr_run while in periodic mode, or a periodic comparator write while ctr_run=1, with a nonzero period P, sets the comparator within 45 cycles to c + P - ((c - K) mod P). Here c is the counter and K the comparator at the start of the realignment. No fire is produced until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctr_run | input | 1 | Global counter run enable |
| ctr_step | input | 1 | Counter has just advanced to ctr_val |
| ctr_val | input | 32 | Shared main counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects configuration word, 1 selects comparator |
| wr_data | input | 64 | Write data (comparator uses bits 31:0) |
| wr_lanes | input | 8 | Byte-lane enables |
| cfg_q | output | 64 | Configuration word |
| cmp_q | output | 32 | Live comparator |
| fire | output | 1 | One-cycle match pulse |

## Verification
The hardest state to reach is a match that falls inside a realignment window. This needs a periodic comparator write while running, followed at once by a counter step onto the freshly written value. The stimulus issues exactly that sequence and then requires silence on fire and the realigned comparator. The period register cannot be read directly. Its value is therefore inferred from how far the comparator moves on a match, and from random realignments in which the counter, comparator and period are drawn so that the remainder spans small, large and zero cases.

// File: rtl/mtc_pkg.sv
// Shared field positions and constants for the comparator timer channel.
// Assumes a 64-bit configuration word whose upper half is the route-capability mask.
package mtc_pkg;
    localparam int CFG_W      = 64;
    localparam int CFG_LANES  = CFG_W / 8;
    localparam int B_MODE_PER = 0;
    localparam int B_ARM      = 1;
    localparam int B_NARROW   = 2;
    localparam int B_ROUTE_LO = 3;
    localparam int ROUTE_W    = 5;
    localparam int B_DIRECT   = 8;
    localparam int B_CAP_PER  = 12;
    localparam int B_CAP_WIDE = 13;
    localparam int B_CAP_DIR  = 14;
    localparam int B_RCAP_LO  = 32;

    localparam logic SEL_CFG = 1'b0;
    localparam logic SEL_CMP = 1'b1;

    // Bits that software may change.
    localparam logic [CFG_W-1:0] CFG_WR_BITS =
        (64'd1 << B_MODE_PER) | (64'd1 << B_ARM) | (64'd1 << B_DIRECT) |
        (((64'd1 << ROUTE_W) - 64'd1) << B_ROUTE_LO);

    // Read-only capability bits below the route-capability half.
    localparam logic [CFG_W-1:0] CFG_CAP_LO =
        (64'd1 << B_CAP_PER) | (64'd1 << B_CAP_DIR);
endpackage

// File: rtl/mtc_cfg_reg.sv
// Configuration word of one channel. Writable fields take byte-lane merged data;
// capability bits are constants, the narrow-force bit reads zero, and the arm
// bit clears itself whenever the comparator is written.
// Assumes wr_cfg and wr_cmp are never high together.
module mtc_cfg_reg
    import mtc_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP_RST = 32'h00F0_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_cfg,
    input  logic                 wr_cmp,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic [CFG_LANES-1:0] wr_lanes,
    output logic [CFG_W-1:0]     cfg_q
);
    localparam logic [CFG_W-1:0] RO_VAL = {ROUTE_CAP_RST, 32'd0} | CFG_CAP_LO;

    logic [CFG_W-1:0] lane_bits;
    logic [CFG_W-1:0] merged;

    // Expand each lane enable to a byte of bit enables.
    for (genvar g = 0; g < CFG_LANES; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{wr_lanes[g]}};
    end

    // Merge write data into the current word under the lane enables.
    assign merged = (cfg_q & ~lane_bits) | (wr_data & lane_bits);

    // Hold the word; only writable fields change, arm clears on comparator writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RO_VAL;
        end else if (wr_cfg) begin
            cfg_q <= (merged & CFG_WR_BITS) | RO_VAL;
        end else if (wr_cmp) begin
            cfg_q[B_ARM] <= 1'b0;
        end
    end
endmodule

// File: rtl/mtc_rem_div.sv
// Sequential restoring remainder unit: rem = num mod den, one bit per cycle.
// Assumes den is nonzero at start; start is ignored by the caller while busy or done.
module mtc_rem_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rem
);
    localparam int SW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  num_q;
    logic [W-1:0]  den_q;
    logic [W:0]    acc;
    logic [W:0]    shifted;
    logic [W:0]    trial;
    logic [SW-1:0] step;

    // One restoring step: bring in the next dividend bit and subtract if it fits.
    always_comb begin
        shifted = {acc[W-1:0], num_q[W-1]};
        trial   = (shifted >= {1'b0, den_q}) ? (shifted - {1'b0, den_q}) : shifted;
    end

    assign rem = acc[W-1:0];

    // Sequence the W steps and pulse done after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q <= '0;
            den_q <= '0;
            acc   <= '0;
            step  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                num_q <= num;
                den_q <= den;
                acc   <= '0;
                step  <= '0;
                busy  <= 1'b1;
            end else if (busy) begin
                acc   <= trial;
                num_q <= num_q << 1;
                step  <= step + 1'b1;
                if (step == SW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mtc_cmp_core.sv
// Comparator, period and match logic of one channel, plus realignment control.
// Assumes the counter value is valid whenever ctr_step is high and that the
// remainder unit result arrives with rem_done.
module mtc_cmp_core #(
    parameter int CW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctr_run,
    input  logic            ctr_step,
    input  logic [CW-1:0]   ctr_val,
    input  logic            wr_cmp,
    input  logic [CW-1:0]   wr_data,
    input  logic [CW/8-1:0] wr_lanes,
    input  logic            mode_per,
    input  logic            arm,
    input  logic            rem_busy,
    input  logic            rem_done,
    input  logic [CW-1:0]   rem_val,
    output logic            rem_start,
    output logic [CW-1:0]   rem_num,
    output logic [CW-1:0]   rem_den,
    output logic [CW-1:0]   cmp_q,
    output logic [CW-1:0]   rate_q,
    output logic            busy,
    output logic            fire
);
    localparam int LANES = CW / 8;

    logic [CW-1:0] lane_bits;
    logic [CW-1:0] cmp_merge;
    logic [CW-1:0] rate_merge;
    logic [CW-1:0] snap_q;
    logic          run_q;
    logic          req_q;
    logic          req_set;
    logic          hit;

    // Expand lane enables for the comparator-width write.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{wr_lanes[g]}};
    end

    // Merged write values for the comparator and the period.
    assign cmp_merge  = (cmp_q  & ~lane_bits) | (wr_data & lane_bits);
    assign rate_merge = (rate_q & ~lane_bits) | (wr_data & lane_bits);

    // Realignment is requested on a run rise or a running periodic write.
    assign req_set   = mode_per & ((ctr_run & ~run_q) | (wr_cmp & ctr_run));
    assign rem_start = req_q & ~rem_busy & ~rem_done & (rate_q != '0);
    assign rem_num   = ctr_val - cmp_q;
    assign rem_den   = rate_q;
    assign busy      = req_q | rem_busy | rem_done;

    // Exact match on a counter step while running and not realigning.
    assign hit = ctr_run & ctr_step & ~busy & (ctr_val == cmp_q);

    // Track run level and the pending realignment request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            run_q <= ctr_run;
            req_q <= req_set | (req_q & (rem_busy | rem_done));
        end
    end

    // Capture the counter the realignment is computed against.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rem_start) begin
            snap_q <= ctr_val;
        end
    end

    // Comparator update: realign result, then writes, then periodic advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (rem_done) begin
            cmp_q <= snap_q + rate_q - rem_val;
        end else if (wr_cmp) begin
            if (mode_per) begin
                if (arm) begin
                    cmp_q <= rate_merge;
                end
            end else begin
                cmp_q <= cmp_merge;
            end
        end else if (hit && mode_per) begin
            cmp_q <= cmp_q + rate_q;
        end
    end

    // Period register: forced to zero outside periodic mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else if (!mode_per) begin
            rate_q <= '0;
        end else if (wr_cmp) begin
            rate_q <= rate_merge;
        end
    end

    // Register the match into a one-cycle fire pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire <= 1'b0;
        end else begin
            fire <= hit;
        end
    end
endmodule

// File: rtl/match_timer_chan.sv
// Top of one comparator timer channel: configuration word, comparator core and
// remainder unit. Assumes one register write per cycle selected by wr_sel.
module match_timer_chan
    import mtc_pkg::*;
#(
    parameter int          CW            = 32,
    parameter logic [31:0] ROUTE_CAP_RST = 32'h00F0_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctr_run,
    input  logic                 ctr_step,
    input  logic [CW-1:0]        ctr_val,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic [CFG_LANES-1:0] wr_lanes,
    output logic [CFG_W-1:0]     cfg_q,
    output logic [CW-1:0]        cmp_q,
    output logic                 fire
);
    localparam int CMP_LANES = CW / 8;

    logic          wr_cfg;
    logic          wr_cmp;
    logic          rem_start;
    logic          rem_busy;
    logic          rem_done;
    logic [CW-1:0] rem_num;
    logic [CW-1:0] rem_den;
    logic [CW-1:0] rem_val;
    logic [CW-1:0] rate_q;
    logic          busy;

    // Decode the write target.
    assign wr_cfg = wr_en & (wr_sel == SEL_CFG);
    assign wr_cmp = wr_en & (wr_sel == SEL_CMP);

    mtc_cfg_reg #(.ROUTE_CAP_RST(ROUTE_CAP_RST)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (wr_cfg),
        .wr_cmp   (wr_cmp),
        .wr_data  (wr_data),
        .wr_lanes (wr_lanes),
        .cfg_q    (cfg_q)
    );

    mtc_cmp_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctr_run   (ctr_run),
        .ctr_step  (ctr_step),
        .ctr_val   (ctr_val),
        .wr_cmp    (wr_cmp),
        .wr_data   (wr_data[CW-1:0]),
        .wr_lanes  (wr_lanes[CMP_LANES-1:0]),
        .mode_per  (cfg_q[B_MODE_PER]),
        .arm       (cfg_q[B_ARM]),
        .rem_busy  (rem_busy),
        .rem_done  (rem_done),
        .rem_val   (rem_val),
        .rem_start (rem_start),
        .rem_num   (rem_num),
        .rem_den   (rem_den),
        .cmp_q     (cmp_q),
        .rate_q    (rate_q),
        .busy      (busy),
        .fire      (fire)
    );

    mtc_rem_div #(.W(CW)) u_rem (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rem_start),
        .num   (rem_num),
        .den   (rem_den),
        .busy  (rem_busy),
        .done  (rem_done),
        .rem   (rem_val)
    );
endmodule

// File: rtl/mtc_chk.sv
// Property checker for the comparator timer channel, bound into the top.
module mtc_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctr_run,
    input logic          ctr_step,
    input logic [CW-1:0] ctr_val,
    input logic          wr_en,
    input logic          wr_sel,
    input logic          wr_lane0,
    input logic          wr_mode_bit,
    input logic          cfg_mode,
    input logic          cfg_arm,
    input logic [31:0]   cfg_caps,
    input logic [CW-1:0] cmp_q,
    input logic [CW-1:0] rate_q,
    input logic          busy,
    input logic          fire
);
    assert_fire_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(ctr_run && ctr_step && (ctr_val == cmp_q)));

    assert_periodic_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(cfg_mode) && !$past(wr_en)) |-> (cmp_q == $past(cmp_q) + $past(rate_q)));

    assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !$past(cfg_mode) && !$past(wr_en)) |-> (cmp_q == $past(cmp_q)));

    assert_arm_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> !cfg_arm);

    assert_rate_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> (rate_q == '0));

    assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !$past(busy));

    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_lane0) |=> (cfg_mode == $past(wr_mode_bit)));

    assert_caps_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> $stable(cfg_caps));
endmodule

bind match_timer_chan mtc_chk #(.CW(CW)) i_mtc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctr_run     (ctr_run),
    .ctr_step    (ctr_step),
    .ctr_val     (ctr_val),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_lane0    (wr_lanes[0]),
    .wr_mode_bit (wr_data[mtc_pkg::B_MODE_PER]),
    .cfg_mode    (cfg_q[mtc_pkg::B_MODE_PER]),
    .cfg_arm     (cfg_q[mtc_pkg::B_ARM]),
    .cfg_caps    (cfg_q[63:32]),
    .cmp_q       (cmp_q),
    .rate_q      (rate_q),
    .busy        (busy),
    .fire        (fire)
);

// File: tb/test_match_timer_chan.sv
module test_match_timer_chan;
    localparam logic [63:0] RO_BITS = 64'h00F00000_00005000;
    localparam logic [63:0] WR_BITS = 64'h0000_0000_0000_01FB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctr_run = 1'b0;
    logic        ctr_step = 1'b0;
    logic [31:0] ctr_val = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_lanes = '0;
    logic [63:0] cfg_q;
    logic [31:0] cmp_q;
    logic        fire;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_cfg;
    logic [31:0] m_cmp;
    logic [31:0] m_rate;

    match_timer_chan i_match_timer_chan (
        .clk(clk), .rst_n(rst_n), .ctr_run(ctr_run), .ctr_step(ctr_step),
        .ctr_val(ctr_val), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_lanes(wr_lanes), .cfg_q(cfg_q), .cmp_q(cmp_q), .fire(fire)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] lane_mask(input logic [7:0] l);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{l[i]}};
        return m;
    endfunction

    function automatic logic [31:0] realign(input logic [31:0] c, input logic [31:0] k,
                                            input logic [31:0] p);
        logic [31:0] d;
        d = c - k;
        return c + p - (d % p);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [63:0] data, input logic [7:0] lanes);
        logic [63:0] lm;
        lm = lane_mask(lanes);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data; wr_lanes = lanes;
        @(negedge clk);
        wr_en = 1'b0;
        if (!sel) begin
            m_cfg = ((((m_cfg & ~lm) | (data & lm)) & WR_BITS) | RO_BITS);
            if (!m_cfg[0]) m_rate = '0;
        end else begin
            if (m_cfg[0]) begin
                m_rate = (m_rate & ~lm[31:0]) | (data[31:0] & lm[31:0]);
                if (m_cfg[1]) m_cmp = m_rate;
            end else begin
                m_cmp = (m_cmp & ~lm[31:0]) | (data[31:0] & lm[31:0]);
            end
            m_cfg[1] = 1'b0;
        end
    endtask

    // One counter step to value v; fire is sampled one cycle later.
    task automatic step_to(input logic [31:0] v, input string tag, input logic exp_fire);
        @(negedge clk);
        ctr_val = v; ctr_step = 1'b1;
        @(negedge clk);
        ctr_step = 1'b0;
        check(tag, {63'd0, fire}, {63'd0, exp_fire});
        if (exp_fire && m_cfg[0]) m_cmp = m_cmp + m_rate;
    endtask

    task automatic settle();
        repeat (45) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r1, r2, c0;
        void'($urandom(32'd20240611));
        m_cfg = RO_BITS; m_cmp = 32'hFFFF_FFFF; m_rate = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg", cfg_q, 64'h00F00000_00005000);
        check("R1 cmp", {32'd0, cmp_q}, 64'hFFFF_FFFF);
        check("R1 fire", {63'd0, fire}, 64'd0);

        // R2 writable fields and read-only capability bits
        wr(1'b0, '1, 8'hFF);
        check("R2 all ones", cfg_q, RO_BITS | WR_BITS);
        wr(1'b0, '0, 8'hFF);
        check("R2 all zeros", cfg_q, RO_BITS);

        // R3 random lane-masked configuration writes
        for (int i = 0; i < 16; i++) begin
            wr(1'b0, {$urandom(), $urandom()}, 8'($urandom()));
            check("R3 cfg lanes", cfg_q, m_cfg);
        end
        wr(1'b0, '0, 8'hFF);

        // R4 one-shot comparator writes with random lanes
        for (int i = 0; i < 16; i++) begin
            wr(1'b1, {32'd0, $urandom()}, 8'($urandom()));
            check("R4 cmp lanes", {32'd0, cmp_q}, {32'd0, m_cmp});
        end

        // R6 match behaviour in one-shot mode
        ctr_run = 1'b1;
        wr(1'b1, 64'd500, 8'h0F);
        step_to(32'd499, "R6 no match", 1'b0);
        step_to(32'd500, "R6 match", 1'b1);
        check("R4 hold after match", {32'd0, cmp_q}, 64'd500);
        @(negedge clk); ctr_run = 1'b0;
        step_to(32'd500, "R6 run low", 1'b0);
        @(negedge clk); ctr_run = 1'b1; ctr_val = 32'd500; ctr_step = 1'b0;
        @(negedge clk);
        check("R6 no step", {63'd0, fire}, 64'd0);
        // R4 value behind the counter waits for wrap
        wr(1'b1, 64'd10, 8'h0F);
        step_to(32'd20, "R4 behind", 1'b0);
        step_to(32'hFFFF_FFFF, "R4 top", 1'b0);
        step_to(32'd0, "R4 wrapped", 1'b0);
        step_to(32'd10, "R4 reached", 1'b1);

        // R5 arm and period behaviour, not running
        @(negedge clk); ctr_run = 1'b0;
        wr(1'b0, 64'd2, 8'hFF);
        wr(1'b1, 64'd77, 8'h0F);
        check("R5 oneshot arm clear", {63'd0, cfg_q[1]}, 64'd0);
        check("R5 oneshot cmp", {32'd0, cmp_q}, 64'd77);
        wr(1'b0, 64'd1, 8'hFF);
        wr(1'b1, 64'd300, 8'h0F);
        check("R5 unarmed keeps cmp", {32'd0, cmp_q}, 64'd77);
        wr(1'b0, 64'd3, 8'hFF);
        wr(1'b1, 64'd1234, 8'h0F);
        check("R5 armed cmp", {32'd0, cmp_q}, 64'd1234);
        check("R5 periodic arm clear", {63'd0, cfg_q[1]}, 64'd0);
        wr(1'b0, 64'd1, 8'hFF);
        wr(1'b1, 64'd200, 8'h0F);

        // R9 realign on run rise
        @(negedge clk); ctr_val = 32'd5000; ctr_run = 1'b1;
        m_cmp = realign(32'd5000, m_cmp, m_rate);
        settle();
        check("R9 rise realign", {32'd0, cmp_q}, 64'd5034);
        // R7 periodic advance
        step_to(32'd5034, "R7 first", 1'b1);
        check("R7 cmp", {32'd0, cmp_q}, {32'd0, m_cmp});
        step_to(m_cmp, "R7 second", 1'b1);
        check("R7 cmp again", {32'd0, cmp_q}, 64'd5434);

        // R8 period cleared with the mode bit
        wr(1'b0, 64'd0, 8'hFF);
        wr(1'b0, 64'd1, 8'hFF);
        step_to(32'd5434, "R8 fire", 1'b1);
        check("R8 cmp unchanged", {32'd0, cmp_q}, 64'd5434);

        // R9 write while running: match suppressed during realignment
        wr(1'b0, 64'd3, 8'hFF);
        c0 = ctr_val;
        wr(1'b1, 64'd9000, 8'h0F);
        step_to(32'd9000, "R9 busy no fire", 1'b0);
        m_cmp = realign(c0, 32'd9000, 32'd9000);
        settle();
        check("R9 write realign", {32'd0, cmp_q}, {32'd0, m_cmp});

        // R9 and R7 random realignments
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); ctr_run = 1'b0;
            r1 = (i % 3 == 0) ? $urandom() : $urandom_range(1, 5000);
            r2 = (i % 3 == 1) ? ($urandom() | 32'd1) : $urandom_range(1, 5000);
            wr(1'b0, 64'd3, 8'hFF);
            wr(1'b1, {32'd0, r1}, 8'h0F);
            wr(1'b0, 64'd1, 8'hFF);
            wr(1'b1, {32'd0, r2}, 8'h0F);
            c0 = (i == 5) ? r1 : $urandom();
            @(negedge clk); ctr_val = c0; ctr_run = 1'b1;
            m_cmp = realign(c0, m_cmp, m_rate);
            settle();
            check("R9 random realign", {32'd0, cmp_q}, {32'd0, m_cmp});
            step_to(m_cmp, "R7 random fire", 1'b1);
            check("R7 random advance", {32'd0, cmp_q}, {32'd0, m_cmp});
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule